// File: doc/BRIEF.md
# Exception Return Unstacking Sequencer

This block restores saved processor state from a memory stack frame when an exception handler returns. A start pulse supplies the frame base address, whether an extended callee-saved context precedes the standard frame, the security state of the return target, and whether the return goes to thread mode. The block then reads the frame one 32-bit word at a time over a valid/ready request port with a separate response channel. Each good word goes straight to a register write port.

A response may report a protection fault, an attribution fault or a bus error. The block stops reading at the first such failure. It classifies the failure, pulses the matching fault-status set strobes, and pends the matching fault exception in the same cycle. One cycle later it requests a tail-chained exception entry instead of a normal return.

Address translation, the register file, the fault status registers and the interrupt controller sit outside the block and appear here only as ports.

Top module: `exc_unstack_seq`

## Requirements
- R1: The standard frame is read in this order at these base offsets, with these destination codes on `rf_idx`: 0x00→0, 0x04→1, 0x08→2, 0x0C→3, 0x10→12, 0x14→14, 0x18→15, 0x1C→16. Code 16 is the program status word.
- R2: With `ext_ctx` set, eight words are read first, from base+0x08 to base+0x24 in steps of 4, into destinations 4 to 11. The standard frame of R1 is then read from base+0x28.
- R3: A response with status 2'b00 (OK) writes `rsp_data` to `rf_idx` through `rf_we` in the cycle the response is accepted. No other cycle asserts `rf_we`.
- R4: Every request carries `req_secure` equal to the latched `tgt_secure` and `req_user` equal to the latched `to_thread`. Both stay constant for the whole sequence.
- R5: On a response status other than OK, no further request is issued and no register is written. `tailchain_req` pulses for one cycle in the next cycle, and `return_done` does not pulse.
- R6: Status 2'b10 (attribution fault) pends exception code 0 (secure fault) with `pend_secure` low. It pulses `attr_viol_set` and `fault_addr_valid_set`, and writes the request address through `fault_addr_we`/`fault_addr`.
- R7: Status 2'b01 (protection fault) pends exception code 1 (memory-management fault) with `pend_secure` equal to the access security. It pulses `mm_unstk_set` with `mm_unstk_bank` equal to that security.
- R8: Status 2'b11 (bus error) pends exception code 2 (bus fault) with `pend_secure` low and pulses `bus_unstk_set`, which targets the non-secure bank.
- R9: After the last word is accepted with OK, `return_done` pulses for one cycle in the next cycle. `return_done` and `tailchain_req` are never high together, and the block is idle one cycle later.
- R10: `start` is ignored while `busy` is high. Changed frame inputs given with it have no effect on the running sequence.
- R11: `req_valid` stays high, with `req_addr` stable, until `req_ready` is seen. No request is raised while a response is awaited.
- R12: After reset the block is idle. `busy`, `req_valid`, `rf_we`, `pend_valid`, `return_done` and `tailchain_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin unstacking (taken only when idle) |
| frame_base | input | 32 | Stack frame base address |
| ext_ctx | input | 1 | Extended callee-saved context present |
| tgt_secure | input | 1 | Return target is in the secure state |
| to_thread | input | 1 | Return goes to thread mode |
| busy | output | 1 | Sequence in progress |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | 32 | Read address |
| req_secure | output | 1 | Access security attribute |
| req_user | output | 1 | Access is unprivileged |
| rsp_valid | input | 1 | Read response valid |
| rsp_status | input | 2 | 00 OK, 01 protection, 10 attribution, 11 bus error |
| rsp_data | input | 32 | Read data |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 5 | Destination register code |
| rf_data | output | 32 | Register write data |
| pend_valid | output | 1 | Pend a fault exception |
| pend_exc | output | 2 | 0 secure fault, 1 memory-management, 2 bus fault |
| pend_secure | output | 1 | Pend to the secure bank |
| attr_viol_set | output | 1 | Set attribution-violation flag |
| fault_addr_valid_set | output | 1 | Set fault-address-valid flag |
| fault_addr_we | output | 1 | Write secure fault address register |
| fault_addr | output | 32 | Faulting address |
| mm_unstk_set | output | 1 | Set memory-management unstacking-error flag |
| mm_unstk_bank | output | 1 | Bank for that flag (1 secure) |
| bus_unstk_set | output | 1 | Set non-secure bus unstacking-error flag |
| return_done | output | 1 | Normal return complete (pulse) |
| tailchain_req | output | 1 | Tail-chained exception entry request (pulse) |

## Verification
On every cycle, the bound checker enforces several rules. Request hold under back-pressure, the silence of the idle state and the constant access attributes during a sequence are checked there. So are the gating of register writes and pends by the response status, the exclusive end pulses, and the fact that no request follows a fault. The word order, the offsets and destination codes, and the base shift after an extended context can only be shown by the bench. The same holds for the fault class chosen for each status, the captured fault address, and the disregard of a start during a running sequence. The bench's scenarios walk full frames with random stalls and inject faults at the first, middle and last words.

// File: rtl/unstk_pkg.sv
package unstk_pkg;
    localparam int AW          = 32;
    localparam int DW          = 32;
    localparam int IW          = 5;
    localparam int STD_WORDS   = 8;
    localparam int EXT_WORDS   = 8;
    localparam int MAX_STEPS   = STD_WORDS + EXT_WORDS;
    localparam int STEP_W      = $clog2(MAX_STEPS);
    localparam int SUB_W       = $clog2(STD_WORDS);
    localparam int EXT_FIRST_REG = 4;
    localparam logic [AW-1:0] EXT_FIRST_OFF = 32'h0000_0008;
    localparam logic [AW-1:0] EXT_SPAN      = 32'h0000_0028;
    localparam logic [IW-1:0] IDX_PSW       = 5'd16;

    typedef enum logic [1:0] {
        RSP_OK   = 2'b00,
        RSP_PROT = 2'b01,
        RSP_ATTR = 2'b10,
        RSP_BUS  = 2'b11
    } rsp_e;

    typedef enum logic [1:0] {
        EXC_SECURE = 2'd0,
        EXC_MEM    = 2'd1,
        EXC_BUS    = 2'd2
    } exc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE,
        ST_CHAIN
    } st_e;

    typedef struct packed {
        logic secure;
        logic user;
    } acc_ctx_t;

    typedef struct packed {
        logic pend;
        exc_e exc;
        logic exc_secure;
        logic attr_viol;
        logic addr_valid;
        logic addr_we;
        logic mm_err;
        logic mm_bank;
        logic bus_err;
    } fault_t;

    // Destination code for word k of the standard frame.
    function automatic logic [IW-1:0] std_dest(input logic [SUB_W-1:0] k);
        logic [IW-1:0] d;
        case (k)
            3'd4:    d = 5'd12;
            3'd5:    d = 5'd14;
            3'd6:    d = 5'd15;
            3'd7:    d = IDX_PSW;
            default: d = IW'(k);
        endcase
        return d;
    endfunction
endpackage

// File: rtl/unstk_step_map.sv
module unstk_step_map
    import unstk_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic              ext,
    input  logic [AW-1:0]     base,
    output logic [AW-1:0]     addr,
    output logic [IW-1:0]     dest,
    output logic              last
);
    logic              in_ext;
    logic [SUB_W-1:0]  k;
    logic [AW-1:0]     off;

    always_comb begin
        k      = step[SUB_W-1:0];
        in_ext = ext && (step < STEP_W'(EXT_WORDS));
        off    = {{(AW-SUB_W-2){1'b0}}, k, 2'b00};
        if (in_ext) begin
            addr = base + EXT_FIRST_OFF + off;
            dest = IW'(EXT_FIRST_REG) + IW'(k);
            last = 1'b0;
        end else begin
            addr = base + (ext ? EXT_SPAN : '0) + off;
            dest = std_dest(k);
            last = (k == SUB_W'(STD_WORDS - 1));
        end
    end
endmodule

// File: rtl/unstk_fault_cls.sv
module unstk_fault_cls
    import unstk_pkg::*;
(
    input  logic [1:0] status,
    input  logic       take,
    input  logic       secure,
    output fault_t     flt
);
    always_comb begin
        flt = '0;
        if (take) begin
            case (rsp_e'(status))
                RSP_ATTR: begin
                    flt.pend       = 1'b1;
                    flt.exc        = EXC_SECURE;
                    flt.exc_secure = 1'b0;
                    flt.attr_viol  = 1'b1;
                    flt.addr_valid = 1'b1;
                    flt.addr_we    = 1'b1;
                end
                RSP_PROT: begin
                    flt.pend       = 1'b1;
                    flt.exc        = EXC_MEM;
                    flt.exc_secure = secure;
                    flt.mm_err     = 1'b1;
                    flt.mm_bank    = secure;
                end
                RSP_BUS: begin
                    flt.pend       = 1'b1;
                    flt.exc        = EXC_BUS;
                    flt.exc_secure = 1'b0;
                    flt.bus_err    = 1'b1;
                end
                default: flt = '0;
            endcase
        end
    end
endmodule

// File: rtl/unstk_fsm.sv
module unstk_fsm
    import unstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic              fault,
    input  logic              last,
    output st_e               state,
    output logic [STEP_W-1:0] step,
    output logic              accept,
    output logic              take
);
    assign accept = (state == ST_IDLE) && start;
    assign take   = (state == ST_WAIT) && rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_REQ;
                    step  <= '0;
                end
                ST_REQ: if (req_ready) state <= ST_WAIT;
                ST_WAIT: if (rsp_valid) begin
                    if (fault)     state <= ST_CHAIN;
                    else if (last) state <= ST_DONE;
                    else begin
                        state <= ST_REQ;
                        step  <= step + 1'b1;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_CHAIN: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/exc_unstack_seq.sv
module exc_unstack_seq
    import unstk_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [31:0]   frame_base,
    input  logic          ext_ctx,
    input  logic          tgt_secure,
    input  logic          to_thread,
    output logic          busy,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [31:0]   req_addr,
    output logic          req_secure,
    output logic          req_user,
    input  logic          rsp_valid,
    input  logic [1:0]    rsp_status,
    input  logic [31:0]   rsp_data,
    output logic          rf_we,
    output logic [4:0]    rf_idx,
    output logic [31:0]   rf_data,
    output logic          pend_valid,
    output logic [1:0]    pend_exc,
    output logic          pend_secure,
    output logic          attr_viol_set,
    output logic          fault_addr_valid_set,
    output logic          fault_addr_we,
    output logic [31:0]   fault_addr,
    output logic          mm_unstk_set,
    output logic          mm_unstk_bank,
    output logic          bus_unstk_set,
    output logic          return_done,
    output logic          tailchain_req
);
    st_e               state;
    logic [STEP_W-1:0] step;
    logic              accept, take, last;
    logic [AW-1:0]     base_q;
    logic              ext_q;
    acc_ctx_t          ctx_q;
    logic [AW-1:0]     cur_addr;
    logic [IW-1:0]     cur_dest;
    fault_t            flt;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ext_q  <= 1'b0;
            ctx_q  <= '0;
        end else if (accept) begin
            base_q       <= frame_base;
            ext_q        <= ext_ctx;
            ctx_q.secure <= tgt_secure;
            ctx_q.user   <= to_thread;
        end
    end

    unstk_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .fault     (flt.pend),
        .last      (last),
        .state     (state),
        .step      (step),
        .accept    (accept),
        .take      (take)
    );

    unstk_step_map u_map (
        .step (step),
        .ext  (ext_q),
        .base (base_q),
        .addr (cur_addr),
        .dest (cur_dest),
        .last (last)
    );

    unstk_fault_cls u_cls (
        .status (rsp_status),
        .take   (take),
        .secure (ctx_q.secure),
        .flt    (flt)
    );

    assign busy       = (state != ST_IDLE);
    assign req_valid  = (state == ST_REQ);
    assign req_addr   = cur_addr;
    assign req_secure = ctx_q.secure;
    assign req_user   = ctx_q.user;

    assign rf_we   = take && !flt.pend;
    assign rf_idx  = cur_dest;
    assign rf_data = rsp_data;

    assign pend_valid           = flt.pend;
    assign pend_exc             = flt.exc;
    assign pend_secure          = flt.exc_secure;
    assign attr_viol_set        = flt.attr_viol;
    assign fault_addr_valid_set = flt.addr_valid;
    assign fault_addr_we        = flt.addr_we;
    assign fault_addr           = cur_addr;
    assign mm_unstk_set         = flt.mm_err;
    assign mm_unstk_bank        = flt.mm_bank;
    assign bus_unstk_set        = flt.bus_err;

    assign return_done   = (state == ST_DONE);
    assign tailchain_req = (state == ST_CHAIN);
endmodule

// File: rtl/unstk_chk.sv
module unstk_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        req_secure,
    input logic        req_user,
    input logic        rsp_valid,
    input logic [1:0]  rsp_status,
    input logic        rf_we,
    input logic        pend_valid,
    input logic        bus_unstk_set,
    input logic        mm_unstk_set,
    input logic        attr_viol_set,
    input logic        return_done,
    input logic        tailchain_req
);
    // R11: request held under back-pressure
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    // R11: no new request right after a handshake (a response is awaited)
    a_r11_wait_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_valid);

    // R3: register writes only on an OK response
    a_r3_we_on_ok: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rsp_valid && rsp_status == 2'b00));

    // R5: a pend only on a failing response, then tail-chain and silence
    a_r5_pend_src: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> (rsp_valid && rsp_status != 2'b00 && !rf_we));

    a_r5_chain_after: assert property (@(posedge clk) disable iff (rst)
        pend_valid |=> (tailchain_req && !req_valid && !return_done));

    // R6/R7/R8: fault flag strobes are mutually exclusive
    a_r8_one_class: assert property (@(posedge clk) disable iff (rst)
        $countones({bus_unstk_set, mm_unstk_set, attr_viol_set}) <= 1);

    // R8: bus unstacking error only from a bus-error status
    a_r8_bus_src: assert property (@(posedge clk) disable iff (rst)
        bus_unstk_set |-> (rsp_status == 2'b11));

    // R9: never both end pulses; each lasts one cycle
    a_r9_excl_end: assert property (@(posedge clk) disable iff (rst)
        !(return_done && tailchain_req));

    a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
        (return_done || tailchain_req) |=> !busy);

    // R4: access attributes constant during a sequence
    a_r4_ctx_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(req_secure) && $stable(req_user)));

    // R12: idle block is silent
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!req_valid && !rf_we && !pend_valid));
endmodule

bind exc_unstack_seq unstk_chk u_chk (.*);

// File: tb/exc_unstack_seq_test.sv
module exc_unstack_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] frame_base = '0;
    logic        ext_ctx = 1'b0;
    logic        tgt_secure = 1'b0;
    logic        to_thread = 1'b0;
    logic        busy, req_valid, req_secure, req_user;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_status = 2'b00;
    logic [31:0] rsp_data = '0;
    logic        rf_we;
    logic [4:0]  rf_idx;
    logic [31:0] rf_data;
    logic        pend_valid, pend_secure;
    logic [1:0]  pend_exc;
    logic        attr_viol_set, fault_addr_valid_set, fault_addr_we;
    logic [31:0] fault_addr;
    logic        mm_unstk_set, mm_unstk_bank, bus_unstk_set;
    logic        return_done, tailchain_req;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    exc_unstack_seq uut (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Expected address for step s (R1, R2)
    function automatic logic [31:0] exp_addr(input logic [31:0] b, input bit e, input int s);
        if (e && s < 8) return b + 32'h8 + 32'(4 * s);
        if (e)          return b + 32'h28 + 32'(4 * (s - 8));
        return b + 32'(4 * s);
    endfunction

    // Expected destination code for step s (R1, R2)
    function automatic logic [4:0] exp_dest(input bit e, input int s);
        int k;
        if (e && s < 8) return 5'(4 + s);
        k = e ? s - 8 : s;
        case (k)
            4: return 5'd12;
            5: return 5'd14;
            6: return 5'd15;
            7: return 5'd16;
            default: return 5'(k);
        endcase
    endfunction

    function automatic logic [31:0] mk_data(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'hC3A5_5A3C;
    endfunction

    task automatic run_case(input logic [31:0] b, input bit e, input bit sec,
                            input bit thr, input int fstep, input logic [1:0] fcode,
                            input bit poke);
        int n;
        bit stop;
        logic [31:0] ea;
        n = e ? 16 : 8;
        stop = 0;
        @(negedge clk);
        frame_base = b; ext_ctx = e; tgt_secure = sec; to_thread = thr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s < n && !stop; s++) begin
            int stall;
            int lat;
            ea = exp_addr(b, e, s);
            chk("R11", "req_valid", 32'(req_valid), 32'd1);
            chk(e ? "R2" : "R1", "req_addr", req_addr, ea);
            chk("R4", "req_secure", 32'(req_secure), 32'(sec));
            chk("R4", "req_user", 32'(req_user), 32'(thr));
            if (poke && s == 0) begin
                // R10: start while busy with different inputs
                start = 1'b1; frame_base = b ^ 32'h0000_FFF0; ext_ctx = ~e;
                tgt_secure = ~sec; to_thread = ~thr;
            end
            stall = $urandom_range(0, 2);
            for (int t = 0; t < stall; t++) begin
                @(negedge clk);
                start = 1'b0;
                chk("R11", "held req_valid", 32'(req_valid), 32'd1);
                chk("R11", "held req_addr", req_addr, ea);
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            start = 1'b0;
            lat = $urandom_range(0, 2);
            for (int t = 0; t < lat; t++) begin
                @(negedge clk);
                chk("R11", "req_valid while waiting", 32'(req_valid), 32'd0);
                chk("R3", "rf_we without response", 32'(rf_we), 32'd0);
            end
            rsp_valid = 1'b1;
            rsp_status = (s == fstep) ? fcode : 2'b00;
            rsp_data = mk_data(ea);
            #1;
            if (s != fstep) begin
                chk("R3", "rf_we", 32'(rf_we), 32'd1);
                chk("R3", "rf_idx", 32'(rf_idx), 32'(exp_dest(e, s)));
                chk("R3", "rf_data", rf_data, mk_data(ea));
                chk("R3", "no pend on OK", 32'(pend_valid), 32'd0);
            end else begin
                chk("R5", "rf_we on fault", 32'(rf_we), 32'd0);
                chk("R5", "pend_valid", 32'(pend_valid), 32'd1);
                case (fcode)
                    2'b10: begin
                        chk("R6", "pend_exc", 32'(pend_exc), 32'd0);
                        chk("R6", "pend_secure", 32'(pend_secure), 32'd0);
                        chk("R6", "attr flags", 32'({attr_viol_set, fault_addr_valid_set, fault_addr_we}), 32'd7);
                        chk("R6", "fault_addr", fault_addr, ea);
                    end
                    2'b01: begin
                        chk("R7", "pend_exc", 32'(pend_exc), 32'd1);
                        chk("R7", "pend_secure", 32'(pend_secure), 32'(sec));
                        chk("R7", "mm_unstk_set", 32'(mm_unstk_set), 32'd1);
                        chk("R7", "mm_unstk_bank", 32'(mm_unstk_bank), 32'(sec));
                        chk("R7", "other flags", 32'({attr_viol_set, bus_unstk_set}), 32'd0);
                    end
                    default: begin
                        chk("R8", "pend_exc", 32'(pend_exc), 32'd2);
                        chk("R8", "pend_secure", 32'(pend_secure), 32'd0);
                        chk("R8", "bus_unstk_set", 32'(bus_unstk_set), 32'd1);
                        chk("R8", "other flags", 32'({attr_viol_set, mm_unstk_set}), 32'd0);
                    end
                endcase
            end
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_status = 2'b00;
            #1;
            if (s == fstep) begin
                chk("R5", "tailchain_req", 32'(tailchain_req), 32'd1);
                chk("R5", "return_done", 32'(return_done), 32'd0);
                chk("R5", "req_valid after fault", 32'(req_valid), 32'd0);
                stop = 1;
            end else if (s == n - 1) begin
                chk("R9", "return_done", 32'(return_done), 32'd1);
                chk("R9", "tailchain_req", 32'(tailchain_req), 32'd0);
            end
        end
        @(negedge clk);
        chk(poke ? "R10" : "R9", "busy after end", 32'(busy), 32'd0);
        chk("R9", "end pulses cleared", 32'({return_done, tailchain_req}), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run hung actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20231));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R12", "busy", 32'(busy), 32'd0);
        chk("R12", "req_valid", 32'(req_valid), 32'd0);
        chk("R12", "rf_we", 32'(rf_we), 32'd0);
        chk("R12", "pend_valid", 32'(pend_valid), 32'd0);
        chk("R12", "end pulses", 32'({return_done, tailchain_req}), 32'd0);

        run_case(32'h2000_1000, 0, 0, 1, -1, 2'b00, 0);   // R1 plain frame
        run_case(32'h2000_2F08, 1, 1, 0, -1, 2'b00, 0);   // R2 extended frame
        run_case(32'h2000_3000, 1, 1, 1,  0, 2'b10, 0);   // R6 first word
        run_case(32'h3000_0040, 1, 0, 0, 15, 2'b11, 0);   // R8 last word
        run_case(32'h1000_0100, 0, 1, 0,  3, 2'b01, 0);   // R7 secure bank
        run_case(32'h1000_0200, 0, 0, 1,  5, 2'b01, 0);   // R7 non-secure bank
        run_case(32'h1000_0300, 1, 0, 1,  8, 2'b10, 0);   // R6 first standard word
        run_case(32'h2400_0800, 1, 1, 0, -1, 2'b00, 1);   // R10 start while busy

        for (int i = 0; i < 40; i++) begin
            logic [31:0] b;
            bit e;
            int fs;
            logic [1:0] fc;
            b  = $urandom & 32'hFFFF_FFF8;
            e  = 1'($urandom_range(0, 1));
            fs = ($urandom_range(0, 2) == 0) ? -1 : $urandom_range(0, e ? 15 : 7);
            fc = 2'($urandom_range(1, 3));
            run_case(b, e, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), fs, fc,
                     1'($urandom_range(0, 3) == 0));
        end
        finish_run();
    end
endmodule